// File: doc/BRIEF.md
# Platform Interrupt Controller

This block collects level-sensitive interrupt lines and hands them out to a set of delivery contexts. Every hart has two contexts, one for machine mode and one for supervisor mode, and each context drives its own external-interrupt line. Each source has a programmable priority and a pending flag. Each context has its own enable mask, priority threshold and claim/complete register.

Software reaches all of this through a single-cycle 32-bit register bus. The bus decodes a fixed sparse map with four regions: priorities, pending words, per-context enable blocks and per-context threshold/claim pages. A handler reads the claim register of its context to take the best waiting source. When it has finished, it writes the same ID back. A source whose line is still high may then pend again.

Top module: `plic_top`

## Requirements
- R1: The priority of source `n` is the word at byte offset `4*n`. Reads return the stored value in bits PRIO_W-1:0. Writes to source 0 are ignored, so source 0 always reads 0.
- R2: Pending word `w` at offset `0x1000 + 4*w` holds the pending flag of source `32*w+k` in bit `k`. The region is read-only.
- R3: Enable word `w` of context `c` sits at `0x2000 + 0x80*c + 4*w`, where bit `k` enables source `32*w+k`. There are `NSRC/32 + 1` words per context, and bit 0 of word 0 always reads 0.
- R4: The threshold of context `c` is at `0x200000 + 0x1000*c`. A source counts for that context only when its priority is strictly greater than the threshold. A threshold of 1 therefore blocks priority-1 sources, and a threshold of 0 admits any nonzero priority.
- R5: Context `2*h` is the machine-mode context of hart `h` and `2*h+1` is its supervisor-mode context. Output bit `extIrq[c]` belongs to context `c`.
- R6: A read of `0x200004 + 0x1000*c` returns the ID of the pending, enabled, above-threshold source with the highest priority. Ties go to the lowest ID. The read returns 0 when no source qualifies.
- R7: A claim read that returns a nonzero ID clears that source's pending flag on the same edge and marks it in service. A source in service never becomes pending.
- R8: Writing an ID to the claim address of any context ends that source's in-service state. If its line is still high, it is pending again two clock edges after the write.
- R9: Source 0 never pends. A source with priority 0 is never reported by a claim read and never raises an output.
- R10: `extIrq[c]` is high exactly when a claim read of context `c` would return a nonzero ID.
- R11: After reset all priorities, enables, thresholds, pending flags and in-service flags are zero, and every output line is low.
- R12: `busReady` equals `busValid`, and read data is valid in the same cycle. Addresses outside the map read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| irqSrc | input | NSRC | level interrupt lines, bit n = source n |
| busValid | input | 1 | register access request |
| busReady | output | 1 | access accepted (same cycle) |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | byte address |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data |
| extIrq | output | 2*NHART | one interrupt line per context |

## Verification
Directed sequences check three behaviours that are easy to mix up:
- equal-priority sources, where the claim result separates a lowest-ID tie break from a highest-ID one;
- thresholds of 0 and 1 against a priority-1 source, which tells a strict comparison from a non-strict one;
- a complete issued while the line is still high, which shows whether the source re-pends and whether it stayed blocked while in service.

A seeded random mix of priority, enable and threshold writes, claims, completes and line toggles then runs on all four contexts. Each cycle it compares every output line and every read word against a bench model. This exposes mistakes in context addressing, in machine/supervisor interleaving and in the enable-bit packing.

// File: rtl/plic_pkg.sv
package plic_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THR,
    RD_CLAIM
  } rdSel_e;

  // strobes from address decode to the register datapath
  typedef struct packed {
    logic        prioWe;
    logic        enWe;
    logic        thrWe;
    logic        claimRd;
    logic        complWr;
    rdSel_e      rdSel;
    logic [15:0] srcIdx;
    logic [7:0]  ctxIdx;
    logic [7:0]  wordIdx;
  } strobe_t;

endpackage

// File: rtl/plic_ctrl.sv
module plic_ctrl
  import plic_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int NCTX     = 4,
  parameter int EN_WORDS = 1,
  parameter int ADDR_W   = 24
) (
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] CTX_BASE  = ADDR_W'(32'h200000);

  logic [ADDR_W-1:0] enOff;
  logic [ADDR_W-1:0] thOff;
  logic [15:0]       wordSel;

  assign enOff   = busAddr - EN_BASE;
  assign thOff   = busAddr - CTX_BASE;
  assign wordSel = {6'd0, busAddr[11:2]};

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (busValid) begin
      if (busAddr < PEND_BASE) begin
        if (wordSel < 16'(NSRC)) begin
          stb.srcIdx = wordSel;
          stb.prioWe = busWe;
          stb.rdSel  = busWe ? RD_NONE : RD_PRIO;
        end
      end else if (busAddr < EN_BASE) begin
        if (wordSel < 16'(EN_WORDS) && !busWe) begin
          stb.wordIdx = 8'(wordSel);
          stb.rdSel   = RD_PEND;
        end
      end else if (busAddr < CTX_BASE) begin
        if (enOff[ADDR_W-1:7] < (ADDR_W-7)'(NCTX) &&
            {3'd0, enOff[6:2]} < 8'(EN_WORDS)) begin
          stb.ctxIdx  = 8'(enOff[ADDR_W-1:7]);
          stb.wordIdx = {3'd0, enOff[6:2]};
          stb.enWe    = busWe;
          stb.rdSel   = busWe ? RD_NONE : RD_EN;
        end
      end else if (thOff[ADDR_W-1:12] < (ADDR_W-12)'(NCTX)) begin
        stb.ctxIdx = 8'(thOff[ADDR_W-1:12]);
        if (thOff[11:0] == 12'h000) begin
          stb.thrWe = busWe;
          stb.rdSel = busWe ? RD_NONE : RD_THR;
        end else if (thOff[11:0] == 12'h004) begin
          stb.complWr = busWe;
          stb.claimRd = !busWe;
          stb.rdSel   = busWe ? RD_NONE : RD_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/plic_datapath.sv
module plic_datapath
  import plic_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int NCTX   = 4,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] irqSrc,
  input  logic [31:0]     busWdata,
  input  strobe_t         stb,
  output logic [31:0]     busRdata,
  output logic [NCTX-1:0] extIrq,
  output logic [NSRC-1:0] pendVec,
  output logic [NSRC-1:0] inSvcVec
);

  logic [PRIO_W-1:0]    prio  [NSRC];
  logic [NSRC-1:0]      en    [NCTX];
  logic [PRIO_W-1:0]    thr   [NCTX];
  logic [NSRC-1:0]      pend;
  logic [NSRC-1:0]      inSvc;
  logic [NCTX*ID_W-1:0] bestFlat;
  logic [ID_W-1:0]      selId;

  assign pendVec  = pend;
  assign inSvcVec = inSvc;

  // per-context arbitration: strict > from the threshold up keeps the lowest ID on ties
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [ID_W-1:0]   bId;
    logic [PRIO_W-1:0] bPr;
    always_comb begin
      bId = '0;
      bPr = thr[c];
      for (int i = 1; i < NSRC; i++) begin
        if (pend[i] && en[c][i] && prio[i] > bPr) begin
          bPr = prio[i];
          bId = ID_W'(i);
        end
      end
    end
    assign bestFlat[c*ID_W +: ID_W] = bId;
    assign extIrq[c] = (bId != '0);
  end

  always_comb begin
    selId = '0;
    for (int c = 0; c < NCTX; c++)
      if (stb.ctxIdx == 8'(c)) selId = bestFlat[c*ID_W +: ID_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pend  <= '0;
      inSvc <= '0;
    end else begin
      for (int i = 1; i < NSRC; i++)
        if (stb.prioWe && stb.srcIdx == 16'(i)) prio[i] <= busWdata[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (stb.thrWe && stb.ctxIdx == 8'(c)) thr[c] <= busWdata[PRIO_W-1:0];
        for (int i = 1; i < NSRC; i++)
          if (stb.enWe && stb.ctxIdx == 8'(c) && stb.wordIdx == 8'(i / 32))
            en[c][i] <= busWdata[i % 32];
      end
      pend[0]  <= 1'b0;
      inSvc[0] <= 1'b0;
      for (int i = 1; i < NSRC; i++) begin
        if (stb.claimRd && selId == ID_W'(i)) begin
          pend[i]  <= 1'b0;
          inSvc[i] <= 1'b1;
        end else begin
          pend[i] <= pend[i] | (irqSrc[i] & ~inSvc[i]);
          if (stb.complWr && busWdata == 32'(i)) inSvc[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (stb.rdSel)
      RD_PRIO:
        for (int i = 0; i < NSRC; i++)
          if (stb.srcIdx == 16'(i)) busRdata = 32'(prio[i]);
      RD_PEND:
        for (int i = 0; i < NSRC; i++)
          if (stb.wordIdx == 8'(i / 32)) busRdata[i % 32] = pend[i];
      RD_EN:
        for (int c = 0; c < NCTX; c++)
          for (int i = 0; i < NSRC; i++)
            if (stb.ctxIdx == 8'(c) && stb.wordIdx == 8'(i / 32)) busRdata[i % 32] = en[c][i];
      RD_THR:
        for (int c = 0; c < NCTX; c++)
          if (stb.ctxIdx == 8'(c)) busRdata = 32'(thr[c]);
      RD_CLAIM: busRdata = 32'(selId);
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/plic_top.sv
module plic_top
  import plic_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NSRC-1:0]      irqSrc,
  input  logic                 busValid,
  output logic                 busReady,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [2*NHART-1:0]   extIrq
);

  localparam int NCTX     = 2 * NHART;
  localparam int EN_WORDS = NSRC / 32 + 1;
  localparam int ID_W     = $clog2(NSRC);

  strobe_t         stb;
  logic [NSRC-1:0] pendVec;
  logic [NSRC-1:0] inSvcVec;

  assign busReady = busValid;

  plic_ctrl #(
    .NSRC(NSRC), .NCTX(NCTX), .EN_WORDS(EN_WORDS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busValid(busValid), .busWe(busWe), .busAddr(busAddr), .stb(stb)
  );

  plic_datapath #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busWdata(busWdata), .stb(stb),
    .busRdata(busRdata), .extIrq(extIrq), .pendVec(pendVec), .inSvcVec(inSvcVec)
  );

endmodule

// File: rtl/plic_chk.sv
module plic_chk #(
  parameter int NSRC   = 16,
  parameter int NCTX   = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic [NCTX-1:0]   extIrq,
  input logic [NSRC-1:0]   pendVec,
  input logic [NSRC-1:0]   inSvcVec
);

  localparam int ID_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] CLAIM0 = ADDR_W'(32'h200004);

  logic            claim0;
  logic            gotId;
  logic [ID_W-1:0] lastId;

  assign claim0 = busValid && !busWe && busAddr == CLAIM0;
  assign gotId  = claim0 && busRdata != 32'd0;

  always_ff @(posedge clk) lastId <= busRdata[ID_W-1:0];

  // R10
  irq_gives_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    claim0 && extIrq[0] |-> busRdata != 32'd0);

  // R6
  idle_claim_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    claim0 && !extIrq[0] |-> busRdata == 32'd0);

  // R7
  claim_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    gotId |=> !pendVec[lastId] && inSvcVec[lastId]);

  // R7
  pend_svc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & inSvcVec) == '0);

  // R9
  src0_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[0] && !inSvcVec[0]);

endmodule

bind plic_top plic_chk #(.NSRC(NSRC), .NCTX(2 * NHART), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe), .busAddr(busAddr),
  .busRdata(busRdata), .extIrq(extIrq), .pendVec(pendVec), .inSvcVec(inSvcVec)
);

// File: tb/plic_top_tb.sv
`timescale 1ns/1ps
module plic_top_tb;
  localparam int NSRC = 16, NHART = 2, NCTX = 4, ADDR_W = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NSRC-1:0] irqSrc = '0, srcNext = '0;
  logic busValid = 1'b0, busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busReady;
  logic [31:0] busRdata;
  logic [NCTX-1:0] extIrq;

  int vectors = 0, fails = 0;
  bit done = 0;

  // bench model
  int mPrio[NSRC];
  bit [NSRC-1:0] mEn[NCTX];
  int mThr[NCTX];
  bit [NSRC-1:0] mPend = '0, mSvc = '0;

  always #2 clk = ~clk;

  plic_top #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(3), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busValid(busValid), .busReady(busReady),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .extIrq(extIrq)
  );

  function automatic int aPrio(int n);  return 4 * n; endfunction
  function automatic int aEn(int c);    return 32'h2000 + 32'h80 * c; endfunction
  function automatic int aThr(int c);   return 32'h200000 + 32'h1000 * c; endfunction
  function automatic int aClaim(int c); return 32'h200004 + 32'h1000 * c; endfunction

  function automatic int best(int c);
    int id = 0, bp = mThr[c];
    for (int i = 1; i < NSRC; i++)
      if (mPend[i] && mEn[c][i] && mPrio[i] > bp) begin bp = mPrio[i]; id = i; end
    return id;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    for (int c = 0; c < NCTX; c++) begin
      if (a == aEn(c)) return 32'(mEn[c]);
      if (a == aThr(c)) return 32'(mThr[c]);
      if (a == aClaim(c)) return 32'(best(c));
    end
    if (a == 32'h1000) return 32'(mPend);
    if (a < 4 * NSRC) return 32'(mPrio[a / 4]);
    return 32'd0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelEdge(bit v, bit we, int a, logic [31:0] d);
    bit [NSRC-1:0] clr = '0, svcSet = '0, svcClr = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (v && !we && a == aClaim(c) && best(c) != 0) begin
        clr[best(c)] = 1'b1; svcSet[best(c)] = 1'b1;
      end
      if (v && we && a == aClaim(c) && d < NSRC) svcClr[d] = 1'b1;
      if (v && we && a == aEn(c)) mEn[c] = d[NSRC-1:0] & ~NSRC'(1);
      if (v && we && a == aThr(c)) mThr[c] = int'(d[2:0]);
    end
    if (v && we && a > 0 && a < 4 * NSRC && a % 4 == 0) mPrio[a / 4] = int'(d[2:0]);
    for (int i = 1; i < NSRC; i++) begin
      if (clr[i]) begin mPend[i] = 0; mSvc[i] = 1; end
      else begin
        mPend[i] = mPend[i] | (irqSrc[i] & ~mSvc[i]);
        if (svcClr[i]) mSvc[i] = 0;
      end
    end
  endtask

  // one bus cycle: drive at negedge, sample 1 ns before the rising edge
  task automatic op(bit v, bit we, int a, logic [31:0] d, string req);
    logic [31:0] exp;
    logic [NCTX-1:0] expIrq;
    @(negedge clk);
    irqSrc = srcNext; busValid = v; busWe = we; busAddr = ADDR_W'(a); busWdata = d;
    #1;
    for (int c = 0; c < NCTX; c++) expIrq[c] = (best(c) != 0);
    chk(extIrq == expIrq, "R10 extIrq", 32'(extIrq), 32'(expIrq));
    chk(busReady == v, "R12 ready", 32'(busReady), 32'(v));
    if (v && !we) begin
      exp = modelRead(a);
      chk(busRdata == exp, req, busRdata, exp);
    end
    modelEdge(v, we, a, d);
    @(posedge clk);
  endtask

  task automatic idle(); op(0, 0, 0, 0, "idle"); endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSRC; i++) mPrio[i] = 0;
    for (int c = 0; c < NCTX; c++) begin mEn[c] = '0; mThr[c] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    op(1, 0, aClaim(0), 0, "R11 claim after reset");
    chk(extIrq == '0, "R11 lines low", 32'(extIrq), 0);
    op(1, 0, aPrio(3), 0, "R11 prio reset");
    op(1, 0, aThr(2), 0, "R11 thr reset");

    // R1 / R9 priority registers
    op(1, 1, aPrio(3), 5, "R1");
    op(1, 0, aPrio(3), 0, "R1 readback");
    op(1, 1, aPrio(0), 7, "R9");
    op(1, 0, aPrio(0), 0, "R9 src0 prio ignored");
    op(1, 1, aPrio(2), 32'hFFFF_FFFF, "R1");
    op(1, 0, aPrio(2), 0, "R1 width");
    // R12 unmapped
    op(1, 1, 32'h1800, 32'hFFFF, "R12");
    op(1, 0, 32'h1800, 0, "R12 unmapped read");

    // R3 enables, bit 0 forced low; R5 supervisor context of hart 0
    op(1, 1, aEn(0), 32'hFFFF, "R3");
    op(1, 0, aEn(0), 0, "R3 en readback");
    chk(busRdata == 32'hFFFE, "R3 en bit0", busRdata, 32'hFFFE);
    op(1, 1, aEn(1), 32'h0008, "R5");

    // R2 / R9 pending with source 0 and 3 high
    srcNext = 16'h0009;
    idle(); idle();
    op(1, 0, 32'h1000, 0, "R2 pending word");
    chk(busRdata == 32'h8, "R2/R9 pend bits", busRdata, 32'h8);
    chk(extIrq == 4'b0011, "R5 m+s of hart0", 32'(extIrq), 32'h3);

    // R4 threshold strictness
    op(1, 1, aThr(0), 5, "R4");
    idle();
    chk(extIrq[0] == 1'b0, "R4 thr equal blocks", 32'(extIrq[0]), 0);
    op(1, 1, aThr(0), 4, "R4");
    idle();
    op(1, 1, aPrio(5), 1, "R4");
    op(1, 1, aEn(2), 32'h0020, "R4");
    op(1, 1, aThr(2), 1, "R4");
    srcNext = 16'h0029;
    idle(); idle();
    chk(extIrq[2] == 1'b0, "R4 thr1 blocks prio1", 32'(extIrq[2]), 0);
    op(1, 1, aThr(2), 0, "R4");
    idle();
    chk(extIrq[2] == 1'b1, "R4 thr0 admits prio1", 32'(extIrq[2]), 1);

    // R9 priority zero never delivered
    op(1, 1, aEn(3), 32'h0080, "R9");
    srcNext = 16'h00A9;
    idle(); idle();
    chk(extIrq[3] == 1'b0, "R9 prio0 silent", 32'(extIrq[3]), 0);

    // R6 tie goes to lowest ID; R7 claim removes pending
    op(1, 1, aPrio(6), 5, "R6");
    srcNext = 16'h00E9;
    idle(); idle();
    op(1, 0, aClaim(0), 0, "R6 tie claim");
    chk(busRdata == 32'd3, "R6 lowest id", busRdata, 3);
    op(1, 0, aClaim(0), 0, "R6 second claim");
    chk(busRdata == 32'd6, "R6 next id", busRdata, 6);
    op(1, 0, 32'h1000, 0, "R7 pending cleared");
    idle(); idle();
    op(1, 0, 32'h1000, 0, "R7 no repend in service");

    // R8 complete with line high re-pends
    op(1, 1, aClaim(1), 3, "R8");
    idle();
    op(1, 0, 32'h1000, 0, "R8 repend");
    chk(busRdata[3] == 1'b1, "R8 source 3 pending", 32'(busRdata[3]), 1);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int kind = int'($urandom_range(0, 7));
      int c = int'($urandom_range(0, NCTX - 1));
      int n = int'($urandom_range(0, NSRC - 1));
      if ($urandom_range(0, 3) == 0) srcNext = 16'($urandom);
      case (kind)
        0: op(1, 1, aPrio(n), $urandom_range(0, 7), "R1 rnd");
        1: op(1, 1, aEn(c), $urandom, "R3 rnd");
        2: op(1, 1, aThr(c), $urandom_range(0, 3), "R4 rnd");
        3, 4: op(1, 0, aClaim(c), 0, "R6 rnd claim");
        5: op(1, 1, aClaim(c), n, "R8 rnd complete");
        6: op(1, 0, 32'h1000, 0, "R2 rnd pending");
        default: op(1, 0, aEn(c), 0, "R3 rnd en read");
      endcase
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule